// File: doc/BRIEF.md
# Key-Protected Flash Command Controller

The block is the command front end of a small on-chip flash array, which is modelled here as a register-based memory. A bus writes control, command and page-buffer words and reads a status word back. A command word only takes effect when its top byte holds the unlock key. After the key check the opcode is decoded and one of several operations starts: page erase, page program, region lock, region unlock, page-buffer clear, quick erased-check or high-speed mode switch. Each operation holds the ready flag low for a modelled busy period and then commits its effect to the array.

Sixteen lock flags divide the page space into equal regions. An erase or program aimed at a locked region is refused at once and raises a sticky lock-error flag. A bad key, an unknown opcode or a command that arrives while the controller is busy raises a sticky programming-error flag. Reading the status word clears both sticky flags. An interrupt output follows the ready flag when the control register enables it.

The sequencer has two states. SQ_IDLE (ready) moves to SQ_BUSY on an accepted command, with a countdown loaded from the operation's latency. SQ_BUSY counts down and, in the cycle its count reaches zero, commits the operation and returns to SQ_IDLE.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status word (address 2) reads 0x00000001, the control word (address 0) reads 0, and every array word reads 0xFFFFFFFF.
- R2: A command is a write to address 1 laid out as key in bits 31:24, page in bits 23:8 (only the low PAGE_W bits select the page) and opcode in bits 5:0. A key other than 0xA5 sets programming error (status bit 3) and changes nothing.
- R3: With a good key, an opcode above 17 sets programming error and starts nothing. Opcodes 0, 6 to 11 and 13 to 15 are accepted with no effect, and ready stays 1.
- R4: Ready (status bit 0) is 0 for exactly LONG_LAT cycles after program (1), erase (2), lock (4) or unlock (5), and for 1 cycle after buffer clear (3), quick check (12) or high-speed on/off (16/17). Control bit 6 set adds one cycle to each of these.
- R5: Erase sets every word of the addressed page to 0xFFFFFFFF and leaves other pages unchanged.
- R6: Writes to address 3 fill the page buffer from word 0 upward and wrap after the last word. Program stores the bitwise AND of the old page and the buffer. Buffer clear sets the buffer to all ones and restarts the fill at word 0.
- R7: Lock and unlock set and clear the flag of region page >> (PAGE_W-4), which is visible as status bit 16+region.
- R8: Erase or program to a page in a locked region leaves the array unchanged, never drops ready, and sets lock error (status bit 2).
- R9: Lock error and programming error stay set until a status read. That read returns them as 1, and the next read returns them as 0.
- R10: A command written while ready is 0 is dropped and sets programming error.
- R11: After a quick check, status bit 5 is 1 when every word of the page is all ones, otherwise 0.
- R12: Opcode 16 sets and opcode 17 clears the high-speed flag (status bit 6).
- R13: The interrupt output equals control bit 0 AND ready.
- R14: Only control bits 0 and 6 are writable. The other control bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Status read strobe (clears sticky flags when the address is 2) |
| bus_addr | input | 2 | Register select: 0 control, 1 command, 2 status, 3 page buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Ready interrupt |
| arr_page | input | PAGE_W | Array read page |
| arr_word | input | WORD_W | Array read word within page |
| arr_data | output | 32 | Array read data |

## Verification
A sequencer stuck in the wrong state shows up as a ready flag that is low for too many or too few cycles. The bench counts these cycles for every one of the 64 opcodes, so such a fault appears within the command that caused it. A wrong decode or a wrong lock decision shows up as a missing or extra error flag at the next status read. Array damage or a commit that never happened is visible on the array read port as soon as ready returns. The model array is compared word by word after every data operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam logic [7:0] CMD_KEY = 8'hA5;
    localparam logic [5:0] OP_MAX  = 6'd17;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CMD  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_BUF  = 2'd3;

    typedef enum logic [3:0] {
        K_NONE, K_PROG, K_ERASE, K_CLRBUF, K_LOCK, K_UNLOCK, K_QREAD, K_HSON, K_HSOFF
    } op_kind_t;

    typedef enum logic {
        SQ_IDLE,
        SQ_BUSY
    } seq_state_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] key,
    input  logic [5:0] opcode,
    output op_kind_t   kind,
    output logic       key_ok,
    output logic       op_bad,
    output logic       long_op
);
    always_comb begin
        key_ok = (key == CMD_KEY);
        op_bad = (opcode > OP_MAX);
        unique case (opcode)
            6'd1:    kind = K_PROG;
            6'd2:    kind = K_ERASE;
            6'd3:    kind = K_CLRBUF;
            6'd4:    kind = K_LOCK;
            6'd5:    kind = K_UNLOCK;
            6'd12:   kind = K_QREAD;
            6'd16:   kind = K_HSON;
            6'd17:   kind = K_HSOFF;
            default: kind = K_NONE;
        endcase
        long_op = (kind == K_PROG) || (kind == K_ERASE) ||
                  (kind == K_LOCK) || (kind == K_UNLOCK);
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] lat,
    output logic             busy,
    output logic             commit
);
    seq_state_t       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st  <= SQ_BUSY;
                        cnt <= lat - CNT_W'(1);
                    end
                end
                SQ_BUSY: begin
                    if (cnt == '0) st <= SQ_IDLE;
                    else           cnt <= cnt - CNT_W'(1);
                end
            endcase
        end
    end

    always_comb begin
        busy   = (st == SQ_BUSY);
        commit = busy && (cnt == '0);
    end

    assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_commit_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
    import flash_cmd_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int WORDS     = 4,
    parameter int PAGE_W    = 5,
    parameter int WORD_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_kind_t          kind,
    input  logic [PAGE_W-1:0] page,
    input  logic              buf_wr,
    input  logic [31:0]       buf_data,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic [WORD_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    output logic [15:0]       locks,
    output logic              qprr
);
    localparam int REGIONS = 16;

    logic [NUM_PAGES-1:0][WORDS-1:0][31:0] mem;
    logic [WORDS-1:0][31:0]                pbuf;
    logic [WORD_W-1:0]                     ptr;
    logic [3:0]                            region;

    assign region  = page[PAGE_W-1 -: 4];
    assign rd_data = mem[rd_page][rd_word];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem  <= '1;
            qprr <= 1'b0;
        end else if (commit) begin
            unique case (kind)
                K_PROG:  mem[page] <= mem[page] & pbuf;
                K_ERASE: mem[page] <= '1;
                K_QREAD: qprr      <= &mem[page];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pbuf <= '1;
            ptr  <= '0;
        end else if (commit && kind == K_CLRBUF) begin
            pbuf <= '1;
            ptr  <= '0;
        end else if (buf_wr) begin
            pbuf[ptr] <= buf_data;
            ptr       <= (ptr == WORD_W'(WORDS - 1)) ? '0 : ptr + WORD_W'(1);
        end
    end

    for (genvar r = 0; r < REGIONS; r++) begin : g_lock
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                locks[r] <= 1'b0;
            else if (commit && region == 4'(r) && kind == K_LOCK)
                locks[r] <= 1'b1;
            else if (commit && region == 4'(r) && kind == K_UNLOCK)
                locks[r] <= 1'b0;
        end
    end

    assert_array_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem));
    assert_locks_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(locks));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter  int NUM_PAGES      = 32,
    parameter  int WORDS_PER_PAGE = 4,
    parameter  int LONG_LAT       = 8,
    localparam int PAGE_W         = $clog2(NUM_PAGES),
    localparam int WORD_W         = $clog2(WORDS_PER_PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic [PAGE_W-1:0] arr_page,
    input  logic [WORD_W-1:0] arr_word,
    output logic [31:0]       arr_data
);
    localparam int CNT_W = $clog2(LONG_LAT + 2);

    logic              ie, ws, locke, proge, hs, qprr;
    logic              busy, commit, start;
    logic [15:0]       locks;
    op_kind_t          kind_in, kind_q;
    logic              key_ok, op_bad, long_op;
    logic [PAGE_W-1:0] page_in, page_q;
    logic              cmd_wr, buf_wr, ctrl_wr, stat_rd;
    logic              valid, is_pe, region_hit, locke_set, proge_set;
    logic [CNT_W-1:0]  lat;
    logic [31:0]       status;

    assign page_in = bus_wdata[8 +: PAGE_W];

    flash_cmd_decode u_dec (
        .key     (bus_wdata[31:24]),
        .opcode  (bus_wdata[5:0]),
        .kind    (kind_in),
        .key_ok  (key_ok),
        .op_bad  (op_bad),
        .long_op (long_op)
    );

    always_comb begin
        cmd_wr     = bus_wr && (bus_addr == A_CMD);
        buf_wr     = bus_wr && (bus_addr == A_BUF);
        ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
        stat_rd    = bus_rd && (bus_addr == A_STAT);
        valid      = cmd_wr && !busy && key_ok && !op_bad;
        is_pe      = (kind_in == K_PROG) || (kind_in == K_ERASE);
        region_hit = locks[page_in[PAGE_W-1 -: 4]];
        start      = valid && (kind_in != K_NONE) && !(is_pe && region_hit);
        locke_set  = valid && is_pe && region_hit;
        proge_set  = cmd_wr && (busy || !key_ok || op_bad);
        lat        = (long_op ? CNT_W'(LONG_LAT) : CNT_W'(1)) + CNT_W'(ws);
    end

    flash_cmd_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .lat    (lat),
        .busy   (busy),
        .commit (commit)
    );

    flash_cmd_array #(
        .NUM_PAGES (NUM_PAGES),
        .WORDS     (WORDS_PER_PAGE),
        .PAGE_W    (PAGE_W),
        .WORD_W    (WORD_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .kind     (kind_q),
        .page     (page_q),
        .buf_wr   (buf_wr),
        .buf_data (bus_wdata),
        .rd_page  (arr_page),
        .rd_word  (arr_word),
        .rd_data  (arr_data),
        .locks    (locks),
        .qprr     (qprr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie     <= 1'b0;
            ws     <= 1'b0;
            hs     <= 1'b0;
            locke  <= 1'b0;
            proge  <= 1'b0;
            kind_q <= K_NONE;
            page_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ie <= bus_wdata[0];
                ws <= bus_wdata[6];
            end
            if (start) begin
                kind_q <= kind_in;
                page_q <= page_in;
            end
            if (commit && kind_q == K_HSON)  hs <= 1'b1;
            if (commit && kind_q == K_HSOFF) hs <= 1'b0;
            if (locke_set)    locke <= 1'b1;
            else if (stat_rd) locke <= 1'b0;
            if (proge_set)    proge <= 1'b1;
            else if (stat_rd) proge <= 1'b0;
        end
    end

    always_comb begin
        status = {locks, 9'b0, hs, qprr, 1'b0, proge, locke, 1'b0, !busy};
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {25'b0, ws, 5'b0, ie};
            A_STAT:  bus_rdata = status;
            default: bus_rdata = 32'b0;
        endcase
        irq = ie && !busy;
    end

    assert_lock_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (kind_in == K_PROG || kind_in == K_ERASE)) |-> !locks[page_in[PAGE_W-1 -: 4]]);
    assert_proge_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proge) |-> $past(cmd_wr));
    assert_locke_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locke) |-> $past(cmd_wr));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
    localparam int NP = 32;
    localparam int NW = 4;
    localparam int LL = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [4:0]  arr_page = 0;
    logic [1:0]  arr_word = 0;
    logic [31:0] arr_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] em [NP][NW];
    logic [31:0] eb [NW];
    int          eptr;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.NUM_PAGES(NP), .WORDS_PER_PAGE(NW), .LONG_LAT(LL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .arr_page(arr_page), .arr_word(arr_word), .arr_data(arr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    function automatic logic [31:0] cw(input logic [7:0] key, input int page, input int op);
        return {key, 16'(page), 2'b00, 6'(op)};
    endfunction

    task automatic wait_ready(output int n);
        n = 0;
        bus_addr = 2'd2;
        #1;
        while (!bus_rdata[0] && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic cmd(input int op, input int page, output int n);
        wr(2'd1, cw(8'hA5, page, op));
        wait_ready(n);
    endtask

    function automatic int exp_lat(input int op, input int wsb);
        case (op)
            1, 2, 4, 5:      return LL + wsb;
            3, 12, 16, 17:   return 1 + wsb;
            default:         return 0;
        endcase
    endfunction

    task automatic m_prog(input int p);
        for (int w = 0; w < NW; w++) em[p][w] = em[p][w] & eb[w];
    endtask
    task automatic m_erase(input int p);
        for (int w = 0; w < NW; w++) em[p][w] = 32'hFFFF_FFFF;
    endtask
    task automatic m_clr();
        for (int w = 0; w < NW; w++) eb[w] = 32'hFFFF_FFFF;
        eptr = 0;
    endtask
    task automatic bufw(input logic [31:0] d);
        wr(2'd3, d);
        eb[eptr] = d;
        eptr = (eptr + 1) % NW;
    endtask

    task automatic chk_page(input string req, input int p);
        for (int w = 0; w < NW; w++) begin
            arr_page = 5'(p); arr_word = 2'(w);
            #1 chk(req, arr_data, em[p][w]);
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        int n, bad;
        for (int p = 0; p < NP; p++) for (int w = 0; w < NW; w++) em[p][w] = 32'hFFFF_FFFF;
        m_clr();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_addr = 2'd2; #1 chk("R1 status", bus_rdata, 32'h1);
        bus_addr = 2'd0; #1 chk("R1 control", bus_rdata, 32'h0);
        bad = 0;
        for (int p = 0; p < NP; p++) for (int w = 0; w < NW; w++) begin
            arr_page = 5'(p); arr_word = 2'(w);
            #1 if (arr_data !== 32'hFFFF_FFFF) bad++;
        end
        chk("R1 array erased", 32'(bad), 32'h0);

        // R14 control writable bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, s); chk("R14 control mask", s, 32'h41);
        wr(2'd0, 32'h0);

        // R13 interrupt follows ready when enabled
        wr(2'd0, 32'h1);
        #1 chk("R13 irq idle", 32'(irq), 32'h1);
        wr(2'd1, cw(8'hA5, 0, 2));
        #1 chk("R13 irq busy", 32'(irq), 32'h0);
        wait_ready(n);
        #1 chk("R13 irq back", 32'(irq), 32'h1);
        wr(2'd0, 32'h0);
        #1 chk("R13 irq disabled", 32'(irq), 32'h0);

        // R3 R4 opcode sweep on page 5
        for (int op = 0; op < 64; op++) begin
            cmd(op, 5, n);
            chk($sformatf("R4 busy op%0d", op), 32'(n), 32'(exp_lat(op, 0)));
            if (op == 3) m_clr();
            rd(2'd2, s);
            chk($sformatf("R3 proge op%0d", op), 32'(s[3]), 32'(op > 17));
            chk($sformatf("R3 no locke op%0d", op), 32'(s[2]), 32'h0);
        end
        rd(2'd2, s);
        chk("R3 sweep end state", s & 32'hFFFF_004D, 32'h1);
        chk_page("R3 page5 intact", 5);

        // R6 buffer fill with wrap, program is AND
        bufw(32'h1111_0000); bufw(32'h2222_FFFF); bufw(32'h3333_0F0F); bufw(32'h4444_F0F0);
        bufw(32'hAAAA_5555); bufw(32'h0F0F_FFFF);
        cmd(1, 7, n); m_prog(7);
        chk_page("R6 program wrap", 7);
        bufw(32'hFF00_FF00); bufw(32'hF0F0_F0F0);
        cmd(1, 7, n); m_prog(7);
        chk_page("R6 program AND", 7);
        cmd(3, 0, n); m_clr();
        bufw(32'h0000_1234);
        cmd(1, 9, n); m_prog(9);
        chk_page("R6 clear restarts fill", 9);

        // R2 bad keys leave page 7 untouched
        foreach (bad_keys[i]) begin
            wr(2'd1, cw(bad_keys[i], 7, 2));
            wait_ready(n);
            chk("R2 bad key no busy", 32'(n), 32'h0);
            rd(2'd2, s);
            chk("R2 bad key proge", 32'(s[3]), 32'h1);
        end
        chk_page("R2 bad key no erase", 7);

        // R2 upper page bits ignored: page 0x27 hits page 7
        cmd(2, 32'h27, n); m_erase(7);
        chk_page("R2 page low bits", 7);

        // R11 quick check
        cmd(12, 9, n);
        rd(2'd2, s); chk("R11 programmed page", 32'(s[5]), 32'h0);
        cmd(12, 7, n);
        rd(2'd2, s); chk("R11 erased page", 32'(s[5]), 32'h1);

        // R7 R8 locks: page 9 and 8 are region 4, page 10 is region 5
        bufw(32'h0);
        cmd(1, 8, n); m_prog(8);
        cmd(4, 9, n);
        rd(2'd2, s); chk("R7 lock bit", s[31:16], 32'h0010);
        cmd(2, 9, n);
        chk("R8 locked no busy", 32'(n), 32'h0);
        chk_page("R8 locked erase", 9);
        rd(2'd2, s); chk("R9 locke set", 32'(s[2]), 32'h1);
        rd(2'd2, s); chk("R9 locke cleared", 32'(s[2]), 32'h0);
        cmd(1, 8, n);
        chk_page("R8 locked program", 8);
        rd(2'd2, s); chk("R8 locke program", 32'(s[2]), 32'h1);
        cmd(2, 10, n); m_erase(10);
        chk("R8 other region runs", 32'(n), 32'(LL));
        cmd(5, 8, n);
        rd(2'd2, s); chk("R7 unlock", s[31:16], 32'h0);
        cmd(2, 9, n); m_erase(9);
        chk_page("R5 erase page", 9);
        chk_page("R5 neighbour kept", 8);

        // R10 command while busy
        wr(2'd1, cw(8'hA5, 11, 2));
        wr(2'd1, cw(8'hA5, 0, 4));
        wait_ready(n);
        rd(2'd2, s);
        chk("R10 proge", 32'(s[3]), 32'h1);
        chk("R10 lock dropped", s[31:16], 32'h0);
        rd(2'd2, s);
        chk("R9 proge cleared", 32'(s[3]), 32'h0);

        // R12 high-speed flag
        cmd(16, 0, n);
        rd(2'd2, s); chk("R12 hs on", 32'(s[6]), 32'h1);
        cmd(17, 0, n);
        rd(2'd2, s); chk("R12 hs off", 32'(s[6]), 32'h0);

        // R4 extra wait state
        wr(2'd0, 32'h40);
        cmd(2, 12, n); m_erase(12);
        chk("R4 long with wait", 32'(n), 32'(LL + 1));
        cmd(3, 0, n); m_clr();
        chk("R4 short with wait", 32'(n), 32'h2);
        cmd(4, 31, n);
        chk("R4 lock with wait", 32'(n), 32'(LL + 1));
        rd(2'd2, s); chk("R7 top region", s[31:16], 32'h8000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [7:0] bad_keys [5] = '{8'h00, 8'hA4, 8'hA6, 8'h5A, 8'hFF};
endmodule